// File: doc/BRIEF.md
# Burst Read Address Sequencer

This block drives the word address for a synchronous burst read out of a memory array. A one-cycle start strobe loads a starting word address. The block then produces one address per clock, together with a data-valid strobe. The burst can be four words, eight words or continuous. Fixed-length bursts either wrap inside their aligned group or run linearly. A continuous burst counts upward and rolls over from the last word to word zero.

A linear burst that does not start on an eight-word boundary may reach the next eight-word boundary. The first time it does, the array needs extra cycles. The block inserts a stall of `latency - words_left_in_first_group` cycles, clamped at zero, and does this at most once per burst. A WAIT output marks the stall. It can drop in the same cycles as the stall, or one cycle earlier, so that a host with a registered input path sees it in time. The configuration inputs are sampled with the start strobe. A new start aborts any burst in progress.

Top module: `burst_seq`

## Requirements
- R1: After reset, `valid_o` is 0 and `wait_o` is 1, and both stay so until a start strobe.
- R2: The first word appears on `addr_o` with `valid_o` = 1 in the cycle after the clock edge that samples `start_i` = 1. A start during a running burst abandons it and begins the new one the same way.
- R3: With `nowrap_i` = 0, `len_i` = 2'b00 (four words) steps only the two low address bits, and `len_i` = 2'b01 (eight words) steps only the three low bits. Each burst delivers exactly 4 or 8 valid words; for example, start 2 gives 2,3,0,1.
- R4: With `nowrap_i` = 1, a four- or eight-word burst increments the whole address by one per valid word and may cross an eight-word boundary.
- R5: With `len_i` = 2'b10 or 2'b11 (continuous), words continue until the next start, and the address rolls over from all-ones to zero.
- R6: A linear burst whose start address has low three bits s ≠ 0 stalls once, on the first step onto an address with low three bits 0. The stall lasts max(0, `latency_i` − (8 − s)) cycles, with `valid_o` = 0 and `addr_o` already holding the next word. An aligned start, or any later crossing, adds no stall.
- R7: With `wait_early_i` = 0, `wait_o` is 0 in exactly the stall cycles and 1 otherwise.
- R8: With `wait_early_i` = 1, `wait_o` is 0 from the cycle before the stall through the second-to-last stall cycle, and 1 otherwise.
- R9: A wrapping burst (`nowrap_i` = 0 with a fixed length) never drives `wait_o` low.
- R10: After the last word of a fixed-length burst, `valid_o` returns to 0 and `wait_o` to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start strobe, one cycle |
| start_addr_i | input | 21 | Starting word address |
| len_i | input | 2 | 00 four, 01 eight, 1x continuous |
| nowrap_i | input | 1 | 0 wrap within group, 1 linear |
| wait_early_i | input | 1 | 1 lowers WAIT one cycle ahead of the stall |
| latency_i | input | 4 | Latency count used to size the stall |
| addr_o | output | 21 | Current word address |
| valid_o | output | 1 | Word on `addr_o` is a data cycle |
| wait_o | output | 1 | 1 data valid, 0 delay in progress |

## Verification
In a continuous burst, address rollover and the boundary stall can fall on the same step. The step from all-ones to zero is also the first eight-word crossing. The bench starts such a burst two words below the top of memory and checks four things: the stall begins with `addr_o` already at zero, it lasts the computed length, the count then continues from zero, and no second stall occurs at word eight. Early WAIT can also coincide with the very first word, which the bench provokes by starting on the last word of a group.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

    // Burst length selector encoding
    typedef enum logic [1:0] {
        LEN_FOUR  = 2'b00,
        LEN_EIGHT = 2'b01,
        LEN_CONT  = 2'b10,
        LEN_CONTX = 2'b11
    } burst_len_e;

    // Size of the group whose first crossing costs latency
    localparam int unsigned GROUP_W = 3;
    localparam int unsigned GROUP_N = 1 << GROUP_W;

endpackage

// File: rtl/burst_cfg_decode.sv
module burst_cfg_decode
    import burst_seq_pkg::*;
(
    input  logic [1:0] len_i,
    input  logic       nowrap_i,
    output logic       cont_o,
    output logic       eight_o,
    output logic       linear_o,
    output logic [2:0] left_init_o
);
    always_comb begin
        cont_o      = 1'b0;
        eight_o     = 1'b0;
        left_init_o = 3'd3;
        case (burst_len_e'(len_i))
            LEN_FOUR:  left_init_o = 3'd3;
            LEN_EIGHT: begin eight_o = 1'b1; left_init_o = 3'd7; end
            default:   begin cont_o = 1'b1; left_init_o = 3'd0; end
        endcase
        linear_o = nowrap_i | cont_o;
    end
endmodule

// File: rtl/burst_delay_calc.sv
module burst_delay_calc
    import burst_seq_pkg::*;
#(
    parameter int unsigned LAT_W = 4
) (
    input  logic [GROUP_W-1:0] start_lo_i,
    input  logic [LAT_W-1:0]   latency_i,
    output logic [LAT_W-1:0]   dly_o
);
    localparam int unsigned REM_W = GROUP_W + 1;
    localparam int unsigned CMP_W = (LAT_W > REM_W) ? LAT_W : REM_W;

    logic [CMP_W-1:0] rem_w;
    logic [CMP_W-1:0] lat_w;
    logic [CMP_W-1:0] diff_w;

    always_comb begin
        rem_w  = CMP_W'(GROUP_N) - CMP_W'(start_lo_i);
        lat_w  = CMP_W'(latency_i);
        diff_w = lat_w - rem_w;
        if (start_lo_i == '0 || lat_w <= rem_w) dly_o = '0;
        else                                   dly_o = LAT_W'(diff_w);
    end
endmodule

// File: rtl/burst_seq.sv
module burst_seq
    import burst_seq_pkg::*;
#(
    parameter int unsigned ADDR_W = 21,
    parameter int unsigned LAT_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] start_addr_i,
    input  logic [1:0]        len_i,
    input  logic              nowrap_i,
    input  logic              wait_early_i,
    input  logic [LAT_W-1:0]  latency_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic              valid_o,
    output logic              wait_o
);

    typedef struct packed {
        logic               active;
        logic               valid;
        logic               stall;
        logic               linear;
        logic               cont;
        logic               eight;
        logic               early;
        logic               crossed;
        logic [GROUP_W-1:0] start_lo;
        logic [2:0]         left;
        logic [LAT_W-1:0]   scnt;
        logic [LAT_W-1:0]   dly;
        logic [ADDR_W-1:0]  addr;
    } seq_st_t;

    seq_st_t st_q, st_d;
    logic    wait_q, wait_d;

    logic             cfg_cont, cfg_eight, cfg_linear;
    logic [2:0]       cfg_left;
    logic [LAT_W-1:0] cfg_dly;

    burst_cfg_decode u_cfg (
        .len_i       (len_i),
        .nowrap_i    (nowrap_i),
        .cont_o      (cfg_cont),
        .eight_o     (cfg_eight),
        .linear_o    (cfg_linear),
        .left_init_o (cfg_left)
    );

    burst_delay_calc #(.LAT_W(LAT_W)) u_dly (
        .start_lo_i (start_addr_i[GROUP_W-1:0]),
        .latency_i  (latency_i),
        .dly_o      (cfg_dly)
    );

    // One clock of progress for a burst, ignoring any new start
    function automatic seq_st_t advance(input seq_st_t s);
        seq_st_t           n;
        logic [ADDR_W-1:0] na;
        n  = s;
        na = s.addr;
        if (!s.active) begin
            n.valid = 1'b0;
            n.stall = 1'b0;
        end else if (s.stall) begin
            if (s.scnt > LAT_W'(1)) begin
                n.scnt = s.scnt - LAT_W'(1);
            end else begin
                n.scnt  = '0;
                n.stall = 1'b0;
                n.valid = 1'b1;
            end
        end else if (!s.cont && s.left == 3'd0) begin
            n.active = 1'b0;
            n.valid  = 1'b0;
        end else begin
            if (s.linear)     na = s.addr + 1'b1;
            else if (s.eight) na = {s.addr[ADDR_W-1:3], s.addr[2:0] + 3'd1};
            else              na = {s.addr[ADDR_W-1:2], s.addr[1:0] + 2'd1};
            n.addr  = na;
            n.valid = 1'b1;
            if (!s.cont) n.left = s.left - 3'd1;
            if (s.linear && na[GROUP_W-1:0] == '0 && !s.crossed) begin
                n.crossed = 1'b1;
                if (s.start_lo != '0 && s.dly != '0) begin
                    n.stall = 1'b1;
                    n.valid = 1'b0;
                    n.scnt  = s.dly;
                end
            end
        end
        return n;
    endfunction

    always_comb begin
        seq_st_t ahead;
        if (start_i) begin
            st_d          = st_q;
            st_d.active   = 1'b1;
            st_d.valid    = 1'b1;
            st_d.stall    = 1'b0;
            st_d.linear   = cfg_linear;
            st_d.cont     = cfg_cont;
            st_d.eight    = cfg_eight;
            st_d.early    = wait_early_i;
            st_d.crossed  = 1'b0;
            st_d.start_lo = start_addr_i[GROUP_W-1:0];
            st_d.left     = cfg_left;
            st_d.scnt     = '0;
            st_d.dly      = cfg_dly;
            st_d.addr     = start_addr_i;
        end else begin
            st_d = advance(st_q);
        end
        ahead  = advance(st_d);
        wait_d = st_d.early ? !ahead.stall : !st_d.stall;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= '0;
            wait_q <= 1'b1;
        end else begin
            st_q   <= st_d;
            wait_q <= wait_d;
        end
    end

    assign addr_o  = st_q.addr;
    assign valid_o = st_q.valid;
    assign wait_o  = wait_q;

    // R9: wrapping bursts keep WAIT high
    p_wrap_no_wait_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.active && !st_q.linear) |-> wait_o);

    // R4: consecutive valid words of a linear burst differ by one
    p_linear_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && $past(valid_o) && !$past(start_i) && st_q.linear)
        |-> addr_o == $past(addr_o) + 1'b1);

    // R3: wrap mode never leaves the aligned eight-word group
    p_wrap_group_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && $past(valid_o) && !$past(start_i) && !st_q.linear)
        |-> addr_o[ADDR_W-1:3] == $past(addr_o[ADDR_W-1:3]));

    // R6: address holds through the stall and into the first word after it
    p_stall_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(st_q.stall) && !$past(start_i)) |-> $stable(addr_o));

    // R6: a burst stalls at most once
    p_single_stall_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(st_q.stall) && !$past(start_i)) |-> !$past(st_q.crossed));

    // R7: same-cycle WAIT mode lowers WAIT only when no data is valid
    p_wait_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.early && !wait_o) |-> !valid_o);

endmodule

// File: tb/burst_seq_test.sv
module burst_seq_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [20:0] start_addr_i = '0;
    logic [1:0]  len_i = '0;
    logic        nowrap_i = 1'b0;
    logic        wait_early_i = 1'b0;
    logic [3:0]  latency_i = '0;
    logic [20:0] addr_o;
    logic        valid_o;
    logic        wait_o;

    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;

    burst_seq uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_addr_i(start_addr_i),
        .len_i(len_i), .nowrap_i(nowrap_i), .wait_early_i(wait_early_i),
        .latency_i(latency_i), .addr_o(addr_o), .valid_o(valid_o), .wait_o(wait_o)
    );

    // check_addr = 0 skips the address compare
    task automatic chk(input string tag, input bit v, input bit check_addr,
                       input logic [20:0] a, input bit w);
        total++;
        if (valid_o !== v || wait_o !== w || (check_addr && addr_o !== a)) begin
            bad++;
            $display("FAIL %s: got v=%0b a=%0h w=%0b, exp v=%0b a=%0h w=%0b",
                     tag, valid_o, addr_o, wait_o, v, a, w);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    // Leaves the bench at the negedge where the first word is visible
    task automatic launch(input logic [20:0] a, input logic [1:0] len, input bit nw,
                          input bit early, input logic [3:0] lat);
        @(negedge clk);
        start_addr_i = a; len_i = len; nowrap_i = nw;
        wait_early_i = early; latency_i = lat; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic t_reset();
        step();
        chk("R1 reset", 1'b0, 1'b1, 21'h0, 1'b1);
        rst_n = 1'b1;
        step(); step();
        chk("R1 idle", 1'b0, 1'b0, 21'h0, 1'b1);
    endtask

    task automatic t_wrap4();
        logic [20:0] e [4] = '{21'd2, 21'd3, 21'd0, 21'd1};
        launch(21'd2, 2'b00, 1'b0, 1'b1, 4'd7);
        for (int i = 0; i < 4; i++) begin
            chk("R3 R9 wrap4", 1'b1, 1'b1, e[i], 1'b1);
            step();
        end
        chk("R10 wrap4 end", 1'b0, 1'b0, 21'h0, 1'b1);
    endtask

    task automatic t_wrap8();
        launch(21'd13, 2'b01, 1'b0, 1'b0, 4'd7);
        for (int i = 0; i < 8; i++) begin
            chk("R3 R9 wrap8", 1'b1, 1'b1, 21'd8 + 21'((5 + i) % 8), 1'b1);
            step();
        end
        chk("R10 wrap8 end", 1'b0, 1'b0, 21'h0, 1'b1);
    endtask

    task automatic t_stall_same();
        launch(21'd7, 2'b00, 1'b1, 1'b0, 4'd5);
        chk("R4 first", 1'b1, 1'b1, 21'd7, 1'b1);
        for (int i = 0; i < 4; i++) begin
            step();
            chk("R6 R7 stall", 1'b0, 1'b1, 21'd8, 1'b0);
        end
        for (int i = 0; i < 3; i++) begin
            step();
            chk("R4 R7 after", 1'b1, 1'b1, 21'd8 + 21'(i), 1'b1);
        end
        step();
        chk("R10 nowrap4 end", 1'b0, 1'b0, 21'h0, 1'b1);
    endtask

    task automatic t_stall_early();
        launch(21'd7, 2'b00, 1'b1, 1'b1, 4'd5);
        chk("R8 word before stall", 1'b1, 1'b1, 21'd7, 1'b0);
        for (int i = 0; i < 4; i++) begin
            step();
            chk("R6 R8 stall", 1'b0, 1'b1, 21'd8, (i == 3) ? 1'b1 : 1'b0);
        end
        for (int i = 0; i < 3; i++) begin
            step();
            chk("R8 after", 1'b1, 1'b1, 21'd8 + 21'(i), 1'b1);
        end
    endtask

    task automatic t_aligned_cont();
        launch(21'd8, 2'b10, 1'b0, 1'b0, 4'd7);
        for (int i = 0; i < 10; i++) begin
            chk("R5 R6 aligned", 1'b1, 1'b1, 21'd8 + 21'(i), 1'b1);
            step();
        end
    endtask

    task automatic t_four_aligned();
        launch(21'd4, 2'b00, 1'b1, 1'b0, 4'd7);
        for (int i = 0; i < 4; i++) begin
            chk("R4 R6 four aligned", 1'b1, 1'b1, 21'd4 + 21'(i), 1'b1);
            step();
        end
        chk("R10 four aligned end", 1'b0, 1'b0, 21'h0, 1'b1);
    endtask

    task automatic t_clamp();
        launch(21'd5, 2'b01, 1'b1, 1'b0, 4'd3);
        for (int i = 0; i < 8; i++) begin
            chk("R4 R6 clamp", 1'b1, 1'b1, 21'd5 + 21'(i), 1'b1);
            step();
        end
        chk("R10 clamp end", 1'b0, 1'b0, 21'h0, 1'b1);
    endtask

    task automatic t_eight_early();
        launch(21'd6, 2'b01, 1'b1, 1'b1, 4'd4);
        chk("R8 w6", 1'b1, 1'b1, 21'd6, 1'b1);
        step(); chk("R8 w7", 1'b1, 1'b1, 21'd7, 1'b0);
        step(); chk("R6 R8 s1", 1'b0, 1'b1, 21'd8, 1'b0);
        step(); chk("R6 R8 s2", 1'b0, 1'b1, 21'd8, 1'b1);
        for (int i = 0; i < 6; i++) begin
            step();
            chk("R4 eight", 1'b1, 1'b1, 21'd8 + 21'(i), 1'b1);
        end
        step();
        chk("R10 eight end", 1'b0, 1'b0, 21'h0, 1'b1);
    endtask

    task automatic t_rollover();
        launch(21'h1FFFFE, 2'b11, 1'b0, 1'b0, 4'd4);
        chk("R5 top-2", 1'b1, 1'b1, 21'h1FFFFE, 1'b1);
        step(); chk("R5 top-1", 1'b1, 1'b1, 21'h1FFFFF, 1'b1);
        for (int i = 0; i < 2; i++) begin
            step();
            chk("R5 R6 R7 roll stall", 1'b0, 1'b1, 21'h0, 1'b0);
        end
        for (int i = 0; i < 12; i++) begin
            step();
            chk("R5 R6 after roll", 1'b1, 1'b1, 21'(i), 1'b1);
        end
    endtask

    task automatic t_abort();
        logic [20:0] e [4] = '{21'd1, 21'd2, 21'd3, 21'd0};
        launch(21'd0, 2'b01, 1'b0, 1'b0, 4'd7);
        step(); step();
        chk("R2 before abort", 1'b1, 1'b1, 21'd2, 1'b1);
        launch(21'd1, 2'b00, 1'b0, 1'b0, 4'd7);
        for (int i = 0; i < 4; i++) begin
            chk("R2 R3 restart", 1'b1, 1'b1, e[i], 1'b1);
            step();
        end
        chk("R2 R10 restart end", 1'b0, 1'b0, 21'h0, 1'b1);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        t_reset();
        t_wrap4();
        t_wrap8();
        t_stall_same();
        t_stall_early();
        t_aligned_cont();
        t_four_aligned();
        t_clamp();
        t_eight_early();
        t_rollover();
        t_abort();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule